// File: doc/BRIEF.md
# Interleaved Burst Protocol Monitor

This block observes a wide transmit interface that runs in interleaved burst mode. In this mode bursts from different channels may alternate while their packets remain open. The monitor tracks which channels have an open packet and whether a burst is currently open. For every cycle that carries data it checks the framing markers against that state. When it finds an illegal sequence it raises a one-cycle error flag. When a packet completes it reports the packet's channel and its total byte length for one cycle.

The monitor is passive and drives nothing back into the interface. It sits beside the producer in a simulation or on silicon as a protocol guard. It does not inspect the payload. A cycle carries up to `WORDS` words of eight bytes each.

Every output is registered. A result therefore appears in the cycle after the input cycle that caused it.

Top module: `ilv_burst_mon`

## Requirements
- R1: After a synchronous active-high reset, every error flag and `rpt_valid` are 0. Every channel is closed and no burst is open.
- R2: A cycle with `in_words` = 0 is idle. It changes no state and produces no flag or report in the next cycle, whatever the other inputs carry.
- R3: The bytes in a data cycle are computed as follows. If `in_eop_code[3]` is 0, the count is 8 × `in_words`. If `in_eop_code[3]` is 1, the count is 8 × (`in_words` − 1), plus `in_eop_code[2:0]` for the last word, or plus 8 when that field is 0. A packet's reported length is the sum over all of its accepted data cycles, modulo 2^`CNT_W`.
- R4: A data cycle with `in_sob` and `in_sop` both set opens a packet on `in_chan` and starts its byte count. If `in_eop_code[3]` is also set, the packet is reported at once, so a one-cycle packet is legal.
- R5: `in_chan` is sampled only when `in_sob` is 1. The cycles that follow, up to and including the one with `in_eob`, belong to that channel. A start-of-burst without start-of-packet adds its bytes to the packet already open on its channel, so bursts of different channels can interleave.
- R6: `err_outside` is set when a data cycle has `in_sob` = 0 and no burst is open. The data in that cycle is discarded.
- R7: `err_sob_in_burst` is set when `in_sob` arrives in a data cycle while a burst is still open. The new burst replaces the old one.
- R8: `err_eop_no_eob` is set when a data cycle has `in_eop_code[3]` = 1 and `in_eob` = 0. The packet is still closed and reported.
- R9: `err_sop_open` is set when a start-of-packet burst targets a channel that already has an open packet. The old count is dropped and a new packet starts.
- R10: `err_cont_closed` is set when a burst start without `in_sop` targets a channel with no open packet. Its data is discarded.
- R11: `err_sop_no_sob` is set when a data cycle has `in_sop` = 1 and `in_sob` = 0. The start-of-packet is otherwise ignored.
- R12: On each cycle that closes an open packet, `rpt_valid` pulses for exactly the following cycle, carrying the channel on `rpt_chan` and the total length on `rpt_bytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_words | input | $clog2(WORDS+1) | Number of valid words this cycle; 0 means idle |
| in_sop | input | 1 | Start of packet |
| in_sob | input | 1 | Start of burst |
| in_eob | input | 1 | End of burst |
| in_eop_code | input | 4 | Bit 3 marks end of packet; bits 2:0 give the valid bytes in the last word (0 means 8) |
| in_chan | input | $clog2(NUM_CH) | Channel number, sampled with start of burst |
| err_outside | output | 1 | Data cycle seen outside any burst |
| err_sob_in_burst | output | 1 | Burst start while a burst is open |
| err_sop_no_sob | output | 1 | Start of packet without start of burst |
| err_eop_no_eob | output | 1 | End of packet without end of burst |
| err_sop_open | output | 1 | New packet on a channel whose packet is open |
| err_cont_closed | output | 1 | Continuation burst on a closed channel |
| rpt_valid | output | 1 | Packet completion report strobe |
| rpt_chan | output | $clog2(NUM_CH) | Channel of the completed packet |
| rpt_bytes | output | CNT_W | Byte length of the completed packet |

## Verification
Several directed patterns are applied first:
- A one-cycle packet, which shows the start and end handling within a single cycle.
- A three-cycle packet of 179 bytes and a full-last-word packet, which separate the two arms of the byte formula.
- A four-burst interleave of two channels, with a stray channel value in a mid-burst cycle, which shows that the channel input is only sampled at a burst start.
- An idle cycle inside a burst that carries every marker set, which shows that idle cycles are truly ignored.

Each of the six illegal sequences is then driven on its own, so that each flag can be told apart from the other five. A long random run with biased markers follows. It mixes legal and illegal traffic across all channels. A reference model in the bench predicts every flag and report in every cycle.

// File: rtl/ilvm_pkg.sv
package ilvm_pkg;

    localparam int unsigned WORD_BYTES = 8;

    // Error flags gathered from the burst tracker and the channel table
    typedef struct packed {
        logic outside;
        logic sob_in_burst;
        logic sop_no_sob;
        logic eop_no_eob;
        logic sop_open;
        logic cont_closed;
    } ilvm_err_t;

    // Decoded view of one input cycle
    typedef struct packed {
        logic data;
        logic sob;
        logic sop;
        logic eob;
        logic eop;
    } ilvm_mark_t;

    // Bytes carried in one cycle, from word count and end-of-packet code
    function automatic int unsigned cycle_bytes(input int unsigned words,
                                                input logic [3:0] code);
        int unsigned last;
        if (words == 0) return 0;
        if (!code[3]) return words * WORD_BYTES;
        last = (code[2:0] == 3'd0) ? WORD_BYTES : int'(code[2:0]);
        return (words - 1) * WORD_BYTES + last;
    endfunction

endpackage

// File: rtl/ilvm_burst_track.sv
module ilvm_burst_track
    import ilvm_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ilvm_mark_t      mark,
    input  logic [CH_W-1:0] chan,
    output logic            take,
    output logic [CH_W-1:0] cyc_ch,
    output logic            e_outside,
    output logic            e_sob_in_burst,
    output logic            e_sop_no_sob,
    output logic            e_eop_no_eob
);

    logic            in_burst_q;
    logic [CH_W-1:0] cur_ch_q;

    // Cycle ownership: a burst start claims the input channel,
    // other data cycles inherit the channel of the open burst.
    always_comb begin
        take           = mark.data && (mark.sob || in_burst_q);
        cyc_ch         = mark.sob ? chan : cur_ch_q;
        e_outside      = mark.data && !mark.sob && !in_burst_q;
        e_sob_in_burst = mark.data && mark.sob && in_burst_q;
        e_sop_no_sob   = mark.data && mark.sop && !mark.sob;
        e_eop_no_eob   = mark.data && mark.eop && !mark.eob;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_burst_q <= 1'b0;
            cur_ch_q   <= '0;
        end else if (mark.data) begin
            if (mark.sob) begin
                in_burst_q <= !mark.eob;
                cur_ch_q   <= chan;
            end else if (in_burst_q) begin
                in_burst_q <= !mark.eob;
            end
        end
    end

    // R2: idle cycles leave the burst state untouched
    p_idle_holds_burst_r2: assert property (@(posedge clk) disable iff (rst)
        !mark.data |=> ($stable(in_burst_q) && $stable(cur_ch_q)));

endmodule

// File: rtl/ilvm_chan_table.sv
module ilvm_chan_table
    import ilvm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  ilvm_mark_t       mark,
    input  logic [CH_W-1:0]  ch,
    input  logic [CNT_W-1:0] bytes,
    output logic             e_sop_open,
    output logic             e_cont_closed,
    output logic             done,
    output logic [CNT_W-1:0] done_bytes
);

    logic [NUM_CH-1:0] open_q;
    logic [CNT_W-1:0]  acc_q [NUM_CH];

    logic             is_sop;
    logic             ch_open;
    logic [CNT_W-1:0] sum;
    logic             wr_open;
    logic             wr_acc;
    logic             nxt_open;
    logic [CNT_W-1:0] nxt_acc;

    always_comb begin
        is_sop        = mark.sob && mark.sop;
        ch_open       = open_q[ch];
        sum           = acc_q[ch] + bytes;
        e_sop_open    = take && is_sop && ch_open;
        e_cont_closed = take && mark.sob && !mark.sop && !ch_open;

        wr_open    = 1'b0;
        wr_acc     = 1'b0;
        nxt_open   = 1'b0;
        nxt_acc    = '0;
        done       = 1'b0;
        done_bytes = '0;
        if (take && is_sop) begin
            wr_open  = 1'b1;
            nxt_open = !mark.eop;
            wr_acc   = 1'b1;
            nxt_acc  = bytes;
            if (mark.eop) begin
                done       = 1'b1;
                done_bytes = bytes;
            end
        end else if (take && ch_open) begin
            wr_acc  = 1'b1;
            nxt_acc = sum;
            if (mark.eop) begin
                wr_open    = 1'b1;
                nxt_open   = 1'b0;
                done       = 1'b1;
                done_bytes = sum;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = (ch == CH_W'(c));
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[c] <= 1'b0;
                acc_q[c]  <= '0;
            end else if (sel) begin
                if (wr_open) open_q[c] <= nxt_open;
                if (wr_acc)  acc_q[c]  <= nxt_acc;
            end
        end
    end

    // R10: discarded continuation data never opens a channel
    p_cont_stays_closed_r10: assert property (@(posedge clk) disable iff (rst)
        e_cont_closed |=> !open_q[$past(ch)]);

    // R4: a start-of-packet cycle without end leaves its channel open
    p_sop_opens_r4: assert property (@(posedge clk) disable iff (rst)
        (take && is_sop && !mark.eop) |=> open_q[$past(ch)]);

endmodule

// File: rtl/ilvm_report.sv
module ilvm_report
    import ilvm_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ilvm_err_t        err_d,
    input  logic             done_d,
    input  logic [CH_W-1:0]  chan_d,
    input  logic [CNT_W-1:0] bytes_d,
    output ilvm_err_t        err_q,
    output logic             done_q,
    output logic [CH_W-1:0]  chan_q,
    output logic [CNT_W-1:0] bytes_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            done_q  <= 1'b0;
            chan_q  <= '0;
            bytes_q <= '0;
        end else begin
            err_q   <= err_d;
            done_q  <= done_d;
            chan_q  <= done_d ? chan_d  : '0;
            bytes_q <= done_d ? bytes_d : '0;
        end
    end

endmodule

// File: rtl/ilv_burst_mon.sv
module ilv_burst_mon
    import ilvm_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int WORDS   = 8,
    parameter int CNT_W   = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int WCNT_W = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WCNT_W-1:0] in_words,
    input  logic              in_sop,
    input  logic              in_sob,
    input  logic              in_eob,
    input  logic [3:0]        in_eop_code,
    input  logic [CH_W-1:0]   in_chan,
    output logic              err_outside,
    output logic              err_sob_in_burst,
    output logic              err_sop_no_sob,
    output logic              err_eop_no_eob,
    output logic              err_sop_open,
    output logic              err_cont_closed,
    output logic              rpt_valid,
    output logic [CH_W-1:0]   rpt_chan,
    output logic [CNT_W-1:0]  rpt_bytes
);

    ilvm_mark_t       mark;
    ilvm_err_t        err_d;
    ilvm_err_t        err_q;
    logic             take;
    logic [CH_W-1:0]  cyc_ch;
    logic [CNT_W-1:0] cyc_bytes;
    logic             done;
    logic [CNT_W-1:0] done_bytes;

    always_comb begin
        mark.data = (in_words != '0);
        mark.sob  = in_sob;
        mark.sop  = in_sop;
        mark.eob  = in_eob;
        mark.eop  = in_eop_code[3];
        cyc_bytes = CNT_W'(cycle_bytes(int'(in_words), in_eop_code));
    end

    ilvm_burst_track #(.CH_W(CH_W)) u_burst (
        .clk            (clk),
        .rst            (rst),
        .mark           (mark),
        .chan           (in_chan),
        .take           (take),
        .cyc_ch         (cyc_ch),
        .e_outside      (err_d.outside),
        .e_sob_in_burst (err_d.sob_in_burst),
        .e_sop_no_sob   (err_d.sop_no_sob),
        .e_eop_no_eob   (err_d.eop_no_eob)
    );

    ilvm_chan_table #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_table (
        .clk           (clk),
        .rst           (rst),
        .take          (take),
        .mark          (mark),
        .ch            (cyc_ch),
        .bytes         (cyc_bytes),
        .e_sop_open    (err_d.sop_open),
        .e_cont_closed (err_d.cont_closed),
        .done          (done),
        .done_bytes    (done_bytes)
    );

    ilvm_report #(.CH_W(CH_W), .CNT_W(CNT_W)) u_rpt (
        .clk     (clk),
        .rst     (rst),
        .err_d   (err_d),
        .done_d  (done),
        .chan_d  (cyc_ch),
        .bytes_d (done_bytes),
        .err_q   (err_q),
        .done_q  (rpt_valid),
        .chan_q  (rpt_chan),
        .bytes_q (rpt_bytes)
    );

    assign err_outside      = err_q.outside;
    assign err_sob_in_burst = err_q.sob_in_burst;
    assign err_sop_no_sob   = err_q.sop_no_sob;
    assign err_eop_no_eob   = err_q.eop_no_eob;
    assign err_sop_open     = err_q.sop_open;
    assign err_cont_closed  = err_q.cont_closed;

    // R2: idle input yields a silent next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_words == '0) |=> (!rpt_valid && err_q == '0));

    // R12: a report always follows an end-of-packet data cycle
    p_rpt_after_eop_r12: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> $past(in_eop_code[3] && in_words != '0));

    // R3: a completed packet always holds at least one byte
    p_rpt_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> (rpt_bytes != '0));

    // R6: data outside a burst is only flagged when no burst start came
    p_outside_no_sob_r6: assert property (@(posedge clk) disable iff (rst)
        err_outside |-> $past(!in_sob));

    // R7: the nested-burst flag follows a burst start
    p_nested_has_sob_r7: assert property (@(posedge clk) disable iff (rst)
        err_sob_in_burst |-> $past(in_sob));

    // R11: the stray start-of-packet flag follows a cycle without burst start
    p_sop_alone_r11: assert property (@(posedge clk) disable iff (rst)
        err_sop_no_sob |-> $past(in_sop && !in_sob));

    // R8: end-of-packet without end-of-burst
    p_eop_no_eob_r8: assert property (@(posedge clk) disable iff (rst)
        err_eop_no_eob |-> $past(in_eop_code[3] && !in_eob));

    // R9: reopening is flagged only for a start-of-packet burst
    p_reopen_is_sop_r9: assert property (@(posedge clk) disable iff (rst)
        err_sop_open |-> $past(in_sop && in_sob));

endmodule

// File: tb/ilv_burst_mon_tb_top.sv
module ilv_burst_mon_tb_top;

    localparam int NUM_CH = 16;
    localparam int WORDS  = 8;
    localparam int CNT_W  = 16;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WCNT_W = $clog2(WORDS + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WCNT_W-1:0] in_words = '0;
    logic              in_sop = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
    logic [3:0]        in_eop_code = '0;
    logic [CH_W-1:0]   in_chan = '0;
    logic              err_outside, err_sob_in_burst, err_sop_no_sob;
    logic              err_eop_no_eob, err_sop_open, err_cont_closed;
    logic              rpt_valid;
    logic [CH_W-1:0]   rpt_chan;
    logic [CNT_W-1:0]  rpt_bytes;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic             m_open [NUM_CH];
    logic [CNT_W-1:0] m_acc  [NUM_CH];
    logic             m_inb;
    logic [CH_W-1:0]  m_cur;

    always #2.5 clk = ~clk;   // 200 MHz

    ilv_burst_mon #(.NUM_CH(NUM_CH), .WORDS(WORDS), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .in_words(in_words), .in_sop(in_sop),
        .in_sob(in_sob), .in_eob(in_eob), .in_eop_code(in_eop_code),
        .in_chan(in_chan), .err_outside(err_outside),
        .err_sob_in_burst(err_sob_in_burst), .err_sop_no_sob(err_sop_no_sob),
        .err_eop_no_eob(err_eop_no_eob), .err_sop_open(err_sop_open),
        .err_cont_closed(err_cont_closed), .rpt_valid(rpt_valid),
        .rpt_chan(rpt_chan), .rpt_bytes(rpt_bytes)
    );

    function automatic logic [CNT_W-1:0] exp_bytes(input int w, input logic [3:0] c);
        int b;
        if (w == 0) return '0;
        if (!c[3]) b = 8 * w;
        else b = 8 * (w - 1) + ((c[2:0] == 3'd0) ? 8 : int'(c[2:0]));
        return CNT_W'(b);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NUM_CH; c++) begin
            m_open[c] = 1'b0;
            m_acc[c]  = '0;
        end
        m_inb = 1'b0;
        m_cur = '0;
    endtask

    // One cycle: predict, drive, clock, compare.
    // Flag vector order: outside, sob_in_burst, sop_no_sob, eop_no_eob, sop_open, cont_closed
    task automatic step(input int w, input logic sop, input logic sob, input logic eob,
                        input logic [3:0] code, input int ch_in, input string tag);
        logic [5:0]       e_err = '0;
        logic             e_rv  = 1'b0;
        logic [CH_W-1:0]  e_ch  = '0;
        logic [CNT_W-1:0] e_by  = '0;
        logic [CNT_W-1:0] b;
        logic [CH_W-1:0]  ch;
        logic             take, eop, issop;
        b   = exp_bytes(w, code);
        eop = code[3];
        if (w != 0) begin
            take  = sob || m_inb;
            ch    = sob ? CH_W'(ch_in) : m_cur;
            issop = sob && sop;
            e_err[5] = !sob && !m_inb;
            e_err[4] = sob && m_inb;
            e_err[3] = sop && !sob;
            e_err[2] = eop && !eob;
            e_err[1] = take && issop && m_open[ch];
            e_err[0] = take && sob && !sop && !m_open[ch];
            if (take && issop) begin
                m_acc[ch] = b;
                m_open[ch] = !eop;
                if (eop) begin e_rv = 1'b1; e_ch = ch; e_by = b; end
            end else if (take && m_open[ch]) begin
                m_acc[ch] = m_acc[ch] + b;
                if (eop) begin
                    m_open[ch] = 1'b0;
                    e_rv = 1'b1; e_ch = ch; e_by = m_acc[ch];
                end
            end
            if (sob) begin m_inb = !eob; m_cur = CH_W'(ch_in); end
            else if (m_inb) m_inb = !eob;
        end
        @(negedge clk);
        in_words = WCNT_W'(w); in_sop = sop; in_sob = sob; in_eob = eob;
        in_eop_code = code; in_chan = CH_W'(ch_in);
        @(posedge clk);
        #1;
        chk(tag, "flags", {err_outside, err_sob_in_burst, err_sop_no_sob,
                           err_eop_no_eob, err_sop_open, err_cont_closed}, e_err);
        chk(tag, "rpt_valid", rpt_valid, e_rv);
        if (e_rv) begin
            chk(tag, "rpt_chan", rpt_chan, e_ch);
            chk(tag, "rpt_bytes", rpt_bytes, e_by);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "flags", {err_outside, err_sob_in_burst, err_sop_no_sob,
                            err_eop_no_eob, err_sop_open, err_cont_closed}, 0);
        chk("R1", "rpt_valid", rpt_valid, 0);

        // R4 single-cycle packet, 2 words, 3 bytes in last word -> 11
        step(2, 1, 1, 1, 4'b1011, 5, "R4");
        // R12 report lasts one cycle
        step(0, 0, 0, 0, 4'b0000, 0, "R12");
        // R3 three cycles 64+64+51 = 179 on channel 2
        step(8, 1, 1, 0, 4'b0000, 2, "R3");
        step(8, 0, 0, 0, 4'b0000, 9, "R3");
        step(7, 0, 0, 1, 4'b1011, 9, "R3");
        // R3 last-word code 0 means full word: 3 words -> 24
        step(3, 1, 1, 1, 4'b1000, 6, "R3");
        // R5 interleave: ch2 open over two bursts with ch4 packet in between
        step(8, 1, 1, 0, 4'b0000, 2, "R5");
        step(8, 0, 0, 1, 4'b0000, 7, "R5");     // stray channel ignored
        step(3, 1, 1, 1, 4'b1011, 4, "R5");     // 19 bytes on ch4
        step(0, 0, 0, 0, 4'b0000, 0, "R5");
        step(8, 0, 1, 1, 4'b0000, 2, "R5");
        step(1, 0, 1, 1, 4'b1000, 2, "R5");     // ch2 total 200
        // R2 idle cycle with all markers set inside a burst
        step(4, 1, 1, 0, 4'b0000, 1, "R2");
        step(0, 1, 1, 1, 4'b1011, 3, "R2");
        step(1, 0, 0, 1, 4'b1000, 3, "R2");     // ch1 total 40
        // R6 data outside burst
        step(2, 0, 0, 0, 4'b0000, 0, "R6");
        // R7 burst start while burst open
        step(2, 1, 1, 0, 4'b0000, 0, "R7");
        step(2, 0, 1, 1, 4'b1000, 0, "R7");
        // R8 end of packet without end of burst
        step(2, 1, 1, 0, 4'b1001, 8, "R8");
        step(1, 0, 0, 1, 4'b0000, 8, "R8");
        // R9 start of packet on an open channel
        step(2, 1, 1, 1, 4'b0000, 10, "R9");
        step(3, 1, 1, 1, 4'b1000, 10, "R9");
        // R10 continuation on a closed channel
        step(2, 0, 1, 1, 4'b1000, 11, "R10");
        // R11 start of packet without burst start
        step(2, 1, 1, 0, 4'b0000, 12, "R11");
        step(2, 1, 0, 1, 4'b1010, 12, "R11");

        // Random phase across all requirements
        for (int i = 0; i < 4000; i++) begin
            int w;
            logic s_sob, s_sop, s_eob;
            logic [3:0] code;
            w     = ($urandom % 5 == 0) ? 0 : 1 + ($urandom % WORDS);
            s_sob = ($urandom % 10) < 4;
            s_sop = s_sob ? (($urandom % 10) < 4) : (($urandom % 20) == 0);
            s_eob = ($urandom % 10) < 4;
            code  = (($urandom % 10) < 3) ? {1'b1, 3'($urandom)} : 4'b0000;
            step(w, s_sop, s_sob, s_eob, code, int'($urandom % NUM_CH), "RND");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule